// File: doc/BRIEF.md
# Delta-Sigma Resonator Sine Oscillator

This block produces a programmable sine excitation for an impedance measurement front end. A coupled-form digital resonator with two integrators runs at the oversampling clock. Its sine state feeds a delta-sigma modulator. The modulator emits a one-bit pulse-density stream that an off-block low-pass filter turns into the analog sine. The signed multi-bit sine sample is also brought out for test.

A 7-bit frequency code sets the resonator coefficient `k = freq_code / 2^KF`. The output period is `2*pi / (2*asin(k/2))` clock cycles, which is close to `fclk*k/(2*pi)` in frequency. Lower output frequencies come from dividing the clock before it reaches the block. A separate 7-bit amplitude code sets the starting state, and with it the peak of the sine. A power-down input holds the loop at its start point. Changing either code restarts the oscillation from phase zero at the new setting.

Top module: `dsr_osc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sample_o` is 0 and `bit_o` is 0 after that edge.
- R2: With both codes held and power-down low, `sample_o` rises through zero once every `2*pi/(2*asin(k/2))` clocks, to within 2 %, where `k = freq_code_i/1024`. The change of `sample_o` between consecutive clocks stays below 2^14.
- R3: With both codes held, the peak of `sample_o` equals `amp_code_i*512/sqrt(1-k*k/4)` to within 3 %.
- R4: `pd_i` high at a clock edge forces `sample_o` to 0 and `bit_o` to 0 after that edge. On the first edge with `pd_i` low again, `sample_o` becomes `(freq_code_i*amp_code_i*512)>>10`, which is the first step of a rising sine.
- R5: A change of either code seen at a clock edge reloads the loop. After that edge `sample_o` is 0 and `bit_o` is 0. One edge later `sample_o` equals `(freq_code_i*amp_code_i*512)>>10`.
- R6: The modulator is first order by default, with feedback of ±2^(W-1). With amplitude code 0, `bit_o` is 0 after the reload edge, then reads 1, 0, 1, 0 … on successive clocks.
- R7: Over whole sine periods the fraction of ones in `bit_o` is 50 % ± 2 %. At amplitude code 127, the ones fraction over the clocks where `sample_o` is positive exceeds 60 %.
- R8: With frequency code 0, `sample_o` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_i | input | 1 | Power-down; 1 stops and holds the oscillator |
| freq_code_i | input | 7 | Frequency code, resonator coefficient numerator |
| amp_code_i | input | 7 | Amplitude code, scales the starting state |
| bit_o | output | 1 | One-bit delta-sigma output stream |
| sample_o | output | W (18) | Signed resonator sine sample for test |

## Verification
The assertions assume the codes and `pd_i` change only between clock edges. They also assume that each run of steady codes the step and toggle checks rely on lasts at least three clocks. The bench drives every input on the falling edge. It holds the codes steady for hundreds of clocks during each frequency, amplitude and density measurement. It changes them only at the starts of scenarios, so every reload is a single clean event.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int CODE_W = 7;
   typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/dsr_sat_add.sv
module dsr_sat_add #(
   parameter int W = 18
) (
   input  logic signed [W-1:0] a_i,
   input  logic signed [W-1:0] b_i,
   input  logic                sub_i,
   output logic signed [W-1:0] y_o
);
   localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   logic signed [W:0] wide;

   always_comb begin
      if (sub_i) wide = {a_i[W-1], a_i} - {b_i[W-1], b_i};
      else       wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
      if (wide[W] != wide[W-1]) y_o = wide[W] ? MINV : MAXV;
      else                      y_o = wide[W-1:0];
   end
endmodule

// File: rtl/dsr_resonator.sv
module dsr_resonator
   import dsr_pkg::*;
#(
   parameter int W  = 18,
   parameter int KF = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reload_i,
   input  code_t               k_i,
   input  logic signed [W-1:0] init_i,
   output logic signed [W-1:0] y_o
);
   localparam int PW = W + CODE_W + 1;

   logic signed [W-1:0] x_q, y_q;
   logic signed [W-1:0] x_n, y_n;
   logic signed [W-1:0] ky, kx;

   // cosine path uses the old sine, sine path uses the new cosine
   always_comb ky = W'((PW'($signed({1'b0, k_i})) * PW'(y_q)) >>> KF);
   always_comb kx = W'((PW'($signed({1'b0, k_i})) * PW'(x_n)) >>> KF);

   dsr_sat_add #(.W(W)) u_add_cos (
      .a_i(x_q), .b_i(ky), .sub_i(1'b1), .y_o(x_n)
   );
   dsr_sat_add #(.W(W)) u_add_sin (
      .a_i(y_q), .b_i(kx), .sub_i(1'b0), .y_o(y_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || reload_i) begin
         x_q <= init_i;
         y_q <= '0;
      end else begin
         x_q <= x_n;
         y_q <= y_n;
      end
   end

   assign y_o = y_q;
endmodule

// File: rtl/dsr_ds_mod.sv
module dsr_ds_mod #(
   parameter int W     = 18,
   parameter int ORDER = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reload_i,
   input  logic signed [W-1:0] x_i,
   output logic                bit_o
);
   localparam int AW = W + 4;
   localparam logic signed [AW-1:0] FBP = {4'b0000, 1'b1, {(W-1){1'b0}}};
   localparam logic signed [AW-1:0] FBN = -FBP;

   logic signed [AW-1:0] xe;
   logic                 q_n;
   logic                 bit_q;

   assign xe = {{4{x_i[W-1]}}, x_i};

   generate
      if (ORDER == 1) begin : g_first
         logic signed [AW-1:0] acc_q, v;
         always_comb v = acc_q + xe;
         assign q_n = ~v[AW-1];
         always_ff @(posedge clk) begin
            if (!rst_n || reload_i) acc_q <= '0;
            else                    acc_q <= v - (q_n ? FBP : FBN);
         end
      end else begin : g_second
         logic signed [AW-1:0] a1_q, a2_q, a1_n, u;
         always_comb begin
            a1_n = a1_q + xe - (bit_q ? FBP : FBN);
            u    = a2_q + a1_n;
         end
         assign q_n = ~u[AW-1];
         always_ff @(posedge clk) begin
            if (!rst_n || reload_i) begin
               a1_q <= '0;
               a2_q <= '0;
            end else begin
               a1_q <= a1_n;
               a2_q <= u - (q_n ? FBP : FBN);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || reload_i) bit_q <= 1'b0;
      else                    bit_q <= q_n;
   end

   assign bit_o = bit_q;
endmodule

// File: rtl/dsr_osc.sv
module dsr_osc
   import dsr_pkg::*;
#(
   parameter int W     = 18,
   parameter int KF    = 10,
   parameter int ORDER = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pd_i,
   input  logic [CODE_W-1:0]        freq_code_i,
   input  logic [CODE_W-1:0]        amp_code_i,
   output logic                     bit_o,
   output logic signed [W-1:0]      sample_o
);
   localparam int AMP_SH = W - 2 - CODE_W;

   initial begin
      assert (AMP_SH >= 0) else $error("dsr_osc: W too small for amplitude code");
      assert (KF >= CODE_W) else $error("dsr_osc: KF must keep k below one");
      assert (ORDER == 1 || ORDER == 2) else $error("dsr_osc: ORDER must be 1 or 2");
   end

   code_t               freq_q, amp_q;
   logic                reload;
   logic signed [W-1:0] init_val;
   logic signed [W-1:0] sine;

   always_ff @(posedge clk) begin
      freq_q <= freq_code_i;
      amp_q  <= amp_code_i;
   end

   assign reload   = pd_i || (freq_code_i != freq_q) || (amp_code_i != amp_q);
   assign init_val = W'(amp_code_i) << AMP_SH;

   dsr_resonator #(.W(W), .KF(KF)) u_res (
      .clk(clk), .rst_n(rst_n), .reload_i(reload),
      .k_i(freq_code_i), .init_i(init_val), .y_o(sine)
   );

   dsr_ds_mod #(.W(W), .ORDER(ORDER)) u_mod (
      .clk(clk), .rst_n(rst_n), .reload_i(reload),
      .x_i(sine), .bit_o(bit_o)
   );

   assign sample_o = sine;
endmodule

// File: rtl/dsr_osc_chk.sv
module dsr_osc_chk
   import dsr_pkg::*;
#(
   parameter int W  = 18,
   parameter int KF = 10
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pd_i,
   input logic [CODE_W-1:0]   freq_code_i,
   input logic [CODE_W-1:0]   amp_code_i,
   input logic                bit_o,
   input logic signed [W-1:0] sample_o
);
   localparam int STEP_LIM = 2 ** (W - 1 + CODE_W - KF);

   code_t               freq_p, amp_p;
   logic signed [W-1:0] prev_s;
   logic                prev_b;
   logic [1:0]          steady, idle;
   logic                chg;
   logic signed [W:0]   dlt;

   assign chg = pd_i || (freq_code_i != freq_p) || (amp_code_i != amp_p);
   assign dlt = {sample_o[W-1], sample_o} - {prev_s[W-1], prev_s};

   always_ff @(posedge clk) begin
      freq_p <= freq_code_i;
      amp_p  <= amp_code_i;
      prev_s <= sample_o;
      prev_b <= bit_o;
      if (!rst_n) begin
         steady <= '0;
         idle   <= '0;
      end else begin
         if (chg)                 steady <= '0;
         else if (steady != 2'd3) steady <= steady + 2'd1;
         if (chg || amp_code_i != '0) idle <= '0;
         else if (idle != 2'd3)       idle <= idle + 2'd1;
      end
   end

   p_pd_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pd_i |=> (sample_o == '0 && !bit_o));

   p_reload_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code_i != freq_p || amp_code_i != amp_p) |=> (sample_o == '0 && !bit_o));

   p_step_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (steady == 2'd3) |-> (dlt < STEP_LIM && dlt > -STEP_LIM));

   p_idle_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle == 2'd3) |-> (bit_o != prev_b));

   p_fzero_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_code_i == '0) |=> (sample_o == '0));
endmodule

bind dsr_osc dsr_osc_chk #(.W(W), .KF(KF)) u_chk (
   .clk(clk), .rst_n(rst_n), .pd_i(pd_i),
   .freq_code_i(freq_code_i), .amp_code_i(amp_code_i),
   .bit_o(bit_o), .sample_o(sample_o)
);

// File: tb/dsr_osc_tb.sv
module dsr_osc_tb;
   localparam int W = 18;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                pd = 1'b0;
   logic [6:0]          fcode = 7'd64;
   logic [6:0]          acode = 7'd127;
   logic                bit_s;
   logic signed [W-1:0] sample;

   int  total = 0;
   int  bad = 0;
   int  cyc = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dsr_osc #(.W(W), .KF(10), .ORDER(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .pd_i(pd),
      .freq_code_i(fcode), .amp_code_i(acode),
      .bit_o(bit_s), .sample_o(sample)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic setup(input int f, input int a, input int settle);
      @(negedge clk);
      fcode = 7'(f);
      acode = 7'(a);
      repeat (settle) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(sample == '0, "R1", "sample in reset", int'(sample), 0);
      chk(bit_s == 1'b0, "R1", "bit in reset", int'(bit_s), 0);
      rst_n = 1'b1;
   endtask

   // R2: period from rising zero crossings
   task automatic t_freq(input int f, input int np);
      int  prev, cur, n, t0;
      real per, expv;
      setup(f, 100, 5);
      prev = int'(sample);
      n = 0; t0 = 0; per = 0.0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         cur = int'(sample);
         if (prev < 0 && cur >= 0) begin
            if (n == 0) t0 = cyc;
            n++;
            if (n == np + 1) begin
               per = real'(cyc - t0) / real'(np);
               break;
            end
         end
         prev = cur;
      end
      expv = 6.283185307 / (2.0 * $asin(real'(f) / 2048.0));
      chk((per - expv) <= 0.02 * expv && (expv - per) <= 0.02 * expv,
          "R2", "period x100", int'(per * 100.0), int'(expv * 100.0));
   endtask

   task automatic t_amp(input int a);
      int  pk;
      real k, expv;
      setup(64, a, 5);
      pk = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (int'(sample) > pk) pk = int'(sample);
      end
      k = 64.0 / 1024.0;
      expv = real'(a) * 512.0 / $sqrt(1.0 - k * k / 4.0);
      chk((real'(pk) - expv) <= 0.03 * expv && (expv - real'(pk)) <= 0.03 * expv,
          "R3", "peak", pk, int'(expv));
   endtask

   task automatic t_pd();
      int errs;
      setup(64, 127, 150);
      pd = 1'b1;
      @(negedge clk);
      chk(sample == '0 && bit_s == 1'b0, "R4", "power-down zero", int'(sample), 0);
      errs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (sample != '0 || bit_s != 1'b0) errs++;
      end
      chk(errs == 0, "R4", "held in power-down", errs, 0);
      pd = 1'b0;
      @(negedge clk);
      chk(int'(sample) == 4064, "R4", "restart step", int'(sample), 4064);
   endtask

   task automatic t_reload();
      setup(64, 127, 137);
      fcode = 7'd32;
      @(negedge clk);
      chk(sample == '0 && bit_s == 1'b0, "R5", "reload zero", int'(sample), 0);
      @(negedge clk);
      chk(int'(sample) == 2032, "R5", "first step after reload", int'(sample), 2032);
   endtask

   task automatic t_idle();
      int errs;
      @(negedge clk);
      acode = 7'd0;
      @(negedge clk);
      chk(bit_s == 1'b0, "R6", "bit after reload", int'(bit_s), 0);
      errs = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (bit_s != ((i % 2) == 0)) errs++;
      end
      chk(errs == 0, "R6", "alternating idle pattern", errs, 0);
   endtask

   task automatic t_density();
      int prev, cur, n, tot, ones, pos, pos_ones;
      setup(64, 127, 5);
      prev = int'(sample);
      n = 0; tot = 0; ones = 0; pos = 0; pos_ones = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         cur = int'(sample);
         if (prev < 0 && cur >= 0) begin
            n++;
            if (n == 11) break;
         end
         if (n >= 1) begin
            tot++;
            if (bit_s) ones++;
            if (cur > 0) begin
               pos++;
               if (bit_s) pos_ones++;
            end
         end
         prev = cur;
      end
      chk(tot > 0 && (ones * 100 - tot * 50) <= tot * 2 && (tot * 50 - ones * 100) <= tot * 2,
          "R7", "ones per mille over periods", (tot > 0) ? ones * 1000 / tot : 0, 500);
      chk(pos > 0 && pos_ones * 100 > pos * 60, "R7", "ones per mille positive half",
          (pos > 0) ? pos_ones * 1000 / pos : 0, 600);
   endtask

   task automatic t_fzero();
      int errs;
      setup(0, 100, 1);
      errs = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (sample != '0) errs++;
      end
      chk(errs == 0, "R8", "flat with zero frequency", errs, 0);
   endtask

   initial begin
      t_reset();
      t_freq(64, 8);
      t_freq(17, 3);
      t_freq(127, 10);
      t_amp(127);
      t_amp(20);
      t_pd();
      t_reload();
      t_idle();
      t_density();
      t_fzero();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule